// File: doc/BRIEF.md
# Memory Operand Address Generator

This unit turns an already-decoded memory-operand mode into the address the bus side needs. From the current base registers (BX, BP), index registers (SI, DI), a displacement of 8 or 16 bits and the AL byte, it forms a 16-bit effective address. It then chooses a segment, either the default one for that mode or one named by an override prefix code. From the segment and the effective address it forms a 20-bit physical address.

Alongside the addresses it reports how many clocks the address calculation costs. It also raises a flag when a word access lands on an odd address and so has to be split into two bus cycles. The decode stage presents one request per cycle with a valid strobe. The results come back registered, one cycle later, with a matching valid pulse.

Top module: `eaddr_gen`

## Requirements
- R1: The physical address equals the selected segment value shifted left by 4 bits, plus the zero-extended effective address, taken modulo 2^20.
- R2: `mode_in` selects the effective address, with every sum taken modulo 2^16. The encodings are: 0 = disp; 1 = BX; 2 = SI; 3 = DI; 4 = BP; 5 = BX+disp; 6 = BP+disp; 7 = SI+disp; 8 = DI+disp; 9 = BX+SI; 10 = BX+DI; 11 = BP+SI; 12 = BP+DI; 13 = BX+SI+disp; 14 = BX+DI+disp; 15 = BP+SI+disp; 16 = BP+DI+disp; 17 = table lookup. Codes 18 to 31 behave as code 0.
- R3: In modes 5, 6, 7, 8 and 13 to 16, when `disp_wide` is 0 only `disp_in[7:0]` is used, sign-extended to 16 bits. When `disp_wide` is 1, all 16 bits are used. Mode 0 always uses all 16 bits.
- R4: With no override in effect, modes 4, 6, 11, 12, 15 and 16 (the modes with BP as base) use `seg_ss`. Every other mode uses `seg_ds`.
- R5: The base cost in clocks is as follows: mode 0 costs 6; modes 1 to 4 cost 5; modes 5 to 8 cost 9; modes 9 and 12 cost 7; modes 10 and 11 cost 8; modes 13 and 16 cost 11; modes 14 and 15 cost 12; mode 17 costs 11.
- R6: When `ovr_valid` is 1, the code 8'h2E selects `seg_cs`, 8'h3E selects `seg_ds`, 8'h26 selects `seg_es` and 8'h36 selects `seg_ss`, and each of these adds 2 to the cost. Any other code leaves both the segment and the cost unchanged.
- R7: When `word_acc` is 1 and the effective address is odd, `split_out` is 1 and the cost rises by 4. Otherwise `split_out` is 0 and nothing is added.
- R8: Mode 17 forms the address as BX plus zero-extended `al_in`. It defaults to `seg_ds`, and it is never split, whatever the value of `word_acc`.
- R9: A request accepted on a rising edge with `req_valid` high appears on the outputs after that edge, with `out_valid` high for exactly that cycle. Without a request, `out_valid` is 0 and all other outputs hold their values. Reset clears every output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| mode_in | input | 5 | Decoded addressing mode (encoding in R2) |
| disp_in | input | 16 | Displacement |
| disp_wide | input | 1 | 1: 16-bit displacement, 0: sign-extended low byte |
| bx_in | input | 16 | BX register value |
| bp_in | input | 16 | BP register value |
| si_in | input | 16 | SI register value |
| di_in | input | 16 | DI register value |
| al_in | input | 8 | AL value for table lookup |
| ovr_valid | input | 1 | An override prefix is present |
| ovr_code | input | 8 | Override prefix byte |
| seg_cs | input | 16 | Code segment value |
| seg_ds | input | 16 | Data segment value |
| seg_es | input | 16 | Extra segment value |
| seg_ss | input | 16 | Stack segment value |
| word_acc | input | 1 | 1 for a word access, 0 for a byte access |
| out_valid | output | 1 | Result valid pulse |
| ea_out | output | 16 | Effective address |
| phys_out | output | 20 | Physical address |
| cost_out | output | 5 | Address-calculation cost in clocks |
| split_out | output | 1 | Word access at an odd address needs two bus cycles |

## Verification
Both penalties can land on one request. A valid override prefix and an odd word address together must raise the cost by exactly 6 and also set the split flag. The bench provokes this with an ES override on a BP-based register pair whose sum is odd, and it compares cost, segment and flag against its own model. A second collision is the wrap of both adders in the same request: the effective-address sum overflows 16 bits on a segment near the top of memory. This checks that each sum wraps at its own width.

// File: rtl/eaddr_pkg.sv
// Package: shared mode codes and per-mode operand selection for the
// address generator. Assumes mode codes arrive already decoded.
package eaddr_pkg;

    typedef enum logic [4:0] {
        M_DIRECT   = 5'd0,
        M_BX       = 5'd1,
        M_SI       = 5'd2,
        M_DI       = 5'd3,
        M_BP       = 5'd4,
        M_BX_D     = 5'd5,
        M_BP_D     = 5'd6,
        M_SI_D     = 5'd7,
        M_DI_D     = 5'd8,
        M_BX_SI    = 5'd9,
        M_BX_DI    = 5'd10,
        M_BP_SI    = 5'd11,
        M_BP_DI    = 5'd12,
        M_BX_SI_D  = 5'd13,
        M_BX_DI_D  = 5'd14,
        M_BP_SI_D  = 5'd15,
        M_BP_DI_D  = 5'd16,
        M_TABLE    = 5'd17
    } mode_t;

    // Which operands a mode adds together.
    typedef struct packed {
        logic use_bx;
        logic use_bp;
        logic use_si;
        logic use_di;
        logic use_disp;   // displacement participates
        logic disp_full;  // displacement forced to full width
        logic use_al;     // table lookup
    } sel_t;

    // Map a mode code to its operand selection; unknown codes act as direct.
    function automatic sel_t mode_sel(input logic [4:0] m);
        sel_t s;
        s = '0;
        case (m)
            M_BX:      s.use_bx = 1'b1;
            M_SI:      s.use_si = 1'b1;
            M_DI:      s.use_di = 1'b1;
            M_BP:      s.use_bp = 1'b1;
            M_BX_D:    begin s.use_bx = 1'b1; s.use_disp = 1'b1; end
            M_BP_D:    begin s.use_bp = 1'b1; s.use_disp = 1'b1; end
            M_SI_D:    begin s.use_si = 1'b1; s.use_disp = 1'b1; end
            M_DI_D:    begin s.use_di = 1'b1; s.use_disp = 1'b1; end
            M_BX_SI:   begin s.use_bx = 1'b1; s.use_si = 1'b1; end
            M_BX_DI:   begin s.use_bx = 1'b1; s.use_di = 1'b1; end
            M_BP_SI:   begin s.use_bp = 1'b1; s.use_si = 1'b1; end
            M_BP_DI:   begin s.use_bp = 1'b1; s.use_di = 1'b1; end
            M_BX_SI_D: begin s.use_bx = 1'b1; s.use_si = 1'b1; s.use_disp = 1'b1; end
            M_BX_DI_D: begin s.use_bx = 1'b1; s.use_di = 1'b1; s.use_disp = 1'b1; end
            M_BP_SI_D: begin s.use_bp = 1'b1; s.use_si = 1'b1; s.use_disp = 1'b1; end
            M_BP_DI_D: begin s.use_bp = 1'b1; s.use_di = 1'b1; s.use_disp = 1'b1; end
            M_TABLE:   begin s.use_bx = 1'b1; s.use_al = 1'b1; end
            default:   begin s.use_disp = 1'b1; s.disp_full = 1'b1; end
        endcase
        return s;
    endfunction

endpackage

// File: rtl/eaddr_sum.sv
// Effective-address adder: sums the selected base, index, displacement
// and table byte, modulo 2^AW. Assumes AW >= 9 so AL and an 8-bit
// displacement fit below the top bit.
module eaddr_sum
    import eaddr_pkg::*;
#(
    parameter int AW = 16,
    parameter int DB = 8      // width of a short displacement
) (
    input  sel_t            sel,
    input  logic            disp_wide,
    input  logic [AW-1:0]   disp,
    input  logic [AW-1:0]   bx,
    input  logic [AW-1:0]   bp,
    input  logic [AW-1:0]   si,
    input  logic [AW-1:0]   di,
    input  logic [DB-1:0]   al,
    output logic [AW-1:0]   ea
);
    logic [AW-1:0] disp_ext;
    logic [AW-1:0] base_t, idx_t, disp_t, al_t;

    // Widen the displacement: full width or sign-extended short form.
    always_comb begin
        if (sel.disp_full || disp_wide)
            disp_ext = disp;
        else
            disp_ext = {{(AW-DB){disp[DB-1]}}, disp[DB-1:0]};
    end

    // Gate each operand by the selection and add them with wraparound.
    always_comb begin
        base_t = sel.use_bx ? bx : (sel.use_bp ? bp : '0);
        idx_t  = sel.use_si ? si : (sel.use_di ? di : '0);
        disp_t = sel.use_disp ? disp_ext : '0;
        al_t   = sel.use_al ? {{(AW-DB){1'b0}}, al} : '0;
        ea     = base_t + idx_t + disp_t + al_t;
    end
endmodule

// File: rtl/eaddr_seg.sv
// Segment selector: BP-based modes default to the stack segment, all
// others to the data segment; a recognised override prefix replaces it.
module eaddr_seg
    import eaddr_pkg::*;
#(
    parameter int SW = 16,
    parameter logic [7:0] CODE_CS = 8'h2E,
    parameter logic [7:0] CODE_DS = 8'h3E,
    parameter logic [7:0] CODE_ES = 8'h26,
    parameter logic [7:0] CODE_SS = 8'h36
) (
    input  sel_t            sel,
    input  logic            ovr_valid,
    input  logic [7:0]      ovr_code,
    input  logic [SW-1:0]   cs,
    input  logic [SW-1:0]   ds,
    input  logic [SW-1:0]   es,
    input  logic [SW-1:0]   ss,
    output logic [SW-1:0]   seg,
    output logic            ovr_hit
);
    // Decode the prefix code, falling back to the mode's default segment.
    always_comb begin
        ovr_hit = 1'b0;
        seg     = sel.use_bp ? ss : ds;
        if (ovr_valid) begin
            case (ovr_code)
                CODE_CS: begin seg = cs; ovr_hit = 1'b1; end
                CODE_DS: begin seg = ds; ovr_hit = 1'b1; end
                CODE_ES: begin seg = es; ovr_hit = 1'b1; end
                CODE_SS: begin seg = ss; ovr_hit = 1'b1; end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/eaddr_cost.sv
// Cost calculator: base clocks per mode, plus the override and
// odd-word penalties; also produces the split-access flag.
module eaddr_cost
    import eaddr_pkg::*;
#(
    parameter int CW          = 5,
    parameter int C_DIRECT    = 6,
    parameter int C_REG       = 5,
    parameter int C_REG_DISP  = 9,
    parameter int C_PAIR_FAST = 7,
    parameter int C_PAIR_SLOW = 8,
    parameter int C_PD_FAST   = 11,
    parameter int C_PD_SLOW   = 12,
    parameter int C_TABLE     = 11,
    parameter int C_OVR       = 2,
    parameter int C_ODD       = 4
) (
    input  logic [4:0]      mode,
    input  logic            ovr_hit,
    input  logic            word_acc,
    input  logic            ea_lsb,
    output logic [CW-1:0]   cost,
    output logic            split
);
    logic [CW-1:0] base_c;

    // Look up the base cost; same-adder-group pairs cost one extra clock.
    always_comb begin
        case (mode)
            M_BX, M_SI, M_DI, M_BP:           base_c = CW'(C_REG);
            M_BX_D, M_BP_D, M_SI_D, M_DI_D:   base_c = CW'(C_REG_DISP);
            M_BX_SI, M_BP_DI:                 base_c = CW'(C_PAIR_FAST);
            M_BX_DI, M_BP_SI:                 base_c = CW'(C_PAIR_SLOW);
            M_BX_SI_D, M_BP_DI_D:             base_c = CW'(C_PD_FAST);
            M_BX_DI_D, M_BP_SI_D:             base_c = CW'(C_PD_SLOW);
            M_TABLE:                          base_c = CW'(C_TABLE);
            default:                          base_c = CW'(C_DIRECT);
        endcase
    end

    // Apply the penalties; the table lookup is always a byte access.
    always_comb begin
        split = word_acc && ea_lsb && (mode != M_TABLE);
        cost  = base_c + (ovr_hit ? CW'(C_OVR) : '0) + (split ? CW'(C_ODD) : '0);
    end
endmodule

// File: rtl/eaddr_gen.sv
// Top: effective and physical address generator with a one-cycle output
// register. Assumes a decoded mode and register values stable while
// req_valid is high; outputs hold between requests.
module eaddr_gen
    import eaddr_pkg::*;
#(
    parameter int AW    = 16,
    parameter int SHIFT = 4,
    parameter int CW    = 5,
    localparam int PW   = AW + SHIFT
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic [4:0]      mode_in,
    input  logic [AW-1:0]   disp_in,
    input  logic            disp_wide,
    input  logic [AW-1:0]   bx_in,
    input  logic [AW-1:0]   bp_in,
    input  logic [AW-1:0]   si_in,
    input  logic [AW-1:0]   di_in,
    input  logic [7:0]      al_in,
    input  logic            ovr_valid,
    input  logic [7:0]      ovr_code,
    input  logic [AW-1:0]   seg_cs,
    input  logic [AW-1:0]   seg_ds,
    input  logic [AW-1:0]   seg_es,
    input  logic [AW-1:0]   seg_ss,
    input  logic            word_acc,
    output logic            out_valid,
    output logic [AW-1:0]   ea_out,
    output logic [PW-1:0]   phys_out,
    output logic [CW-1:0]   cost_out,
    output logic            split_out
);
    sel_t          sel;
    logic [AW-1:0] ea_c;
    logic [AW-1:0] seg_c;
    logic          ovr_hit;
    logic [CW-1:0] cost_c;
    logic          split_c;
    logic [PW-1:0] phys_c;

    // Decode the mode into an operand selection.
    always_comb sel = mode_sel(mode_in);

    eaddr_sum #(.AW(AW), .DB(8)) u_sum (
        .sel(sel), .disp_wide(disp_wide), .disp(disp_in),
        .bx(bx_in), .bp(bp_in), .si(si_in), .di(di_in), .al(al_in),
        .ea(ea_c)
    );

    eaddr_seg #(.SW(AW)) u_seg (
        .sel(sel), .ovr_valid(ovr_valid), .ovr_code(ovr_code),
        .cs(seg_cs), .ds(seg_ds), .es(seg_es), .ss(seg_ss),
        .seg(seg_c), .ovr_hit(ovr_hit)
    );

    eaddr_cost #(.CW(CW)) u_cost (
        .mode(mode_in), .ovr_hit(ovr_hit), .word_acc(word_acc),
        .ea_lsb(ea_c[0]), .cost(cost_c), .split(split_c)
    );

    // Shift the segment and add the offset, wrapping at PW bits.
    always_comb phys_c = {seg_c, {SHIFT{1'b0}}} + {{SHIFT{1'b0}}, ea_c};

    // Register the results on a request and hold them otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            ea_out    <= '0;
            phys_out  <= '0;
            cost_out  <= '0;
            split_out <= 1'b0;
        end else begin
            out_valid <= req_valid;
            if (req_valid) begin
                ea_out    <= ea_c;
                phys_out  <= phys_c;
                cost_out  <= cost_c;
                split_out <= split_c;
            end
        end
    end
endmodule

// File: rtl/eaddr_gen_chk.sv
// Checker: temporal properties of the address generator's ports,
// attached to every instance through a bind.
module eaddr_gen_chk #(
    parameter int AW = 16,
    parameter int PW = 20,
    parameter int CW = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic          out_valid,
    input logic [AW-1:0] ea_out,
    input logic [PW-1:0] phys_out,
    input logic [CW-1:0] cost_out,
    input logic          split_out
);
    // R9
    valid_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> out_valid);
    // R9
    no_spurious_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !out_valid);
    // R9
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> ($stable(ea_out) && $stable(phys_out) && $stable(cost_out)));
    // R7
    split_needs_odd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && split_out) |-> (ea_out[0] && cost_out >= CW'(9)));
    // R5
    cost_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (cost_out >= CW'(5) && cost_out <= CW'(18)));
endmodule

bind eaddr_gen eaddr_gen_chk #(.AW(AW), .PW(PW), .CW(CW)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .out_valid(out_valid),
    .ea_out(ea_out), .phys_out(phys_out), .cost_out(cost_out),
    .split_out(split_out)
);

// File: tb/eaddr_gen_tb.sv
// Scoreboard bench: the driver pushes modelled results, the monitor
// pops and compares them when out_valid rises.
module eaddr_gen_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [4:0]  mode_in = '0;
    logic [15:0] disp_in = '0;
    logic        disp_wide = 1'b0;
    logic [15:0] bx_in = '0, bp_in = '0, si_in = '0, di_in = '0;
    logic [7:0]  al_in = '0;
    logic        ovr_valid = 1'b0;
    logic [7:0]  ovr_code = '0;
    logic [15:0] seg_cs = 16'h1000, seg_ds = 16'h2000, seg_es = 16'h3000, seg_ss = 16'h4000;
    logic        word_acc = 1'b0;
    logic        out_valid;
    logic [15:0] ea_out;
    logic [19:0] phys_out;
    logic [4:0]  cost_out;
    logic        split_out;

    typedef struct {
        logic [15:0] ea;
        logic [19:0] phys;
        logic [4:0]  cost;
        logic        split;
        string       tag;
    } exp_t;

    exp_t q[$];
    exp_t last_exp;
    int   n_vec = 0;
    int   n_bad = 0;

    always #10 clk = ~clk;

    eaddr_gen u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .mode_in(mode_in),
        .disp_in(disp_in), .disp_wide(disp_wide), .bx_in(bx_in), .bp_in(bp_in),
        .si_in(si_in), .di_in(di_in), .al_in(al_in), .ovr_valid(ovr_valid),
        .ovr_code(ovr_code), .seg_cs(seg_cs), .seg_ds(seg_ds), .seg_es(seg_es),
        .seg_ss(seg_ss), .word_acc(word_acc), .out_valid(out_valid),
        .ea_out(ea_out), .phys_out(phys_out), .cost_out(cost_out),
        .split_out(split_out)
    );

    // Reference model written from the requirements.
    function automatic exp_t model(string tag);
        exp_t e;
        logic [15:0] d8, d, seg;
        int c;
        bit bp_base, ovr, tbl;
        d8 = {{8{disp_in[7]}}, disp_in[7:0]};
        d  = disp_wide ? disp_in : d8;
        bp_base = 1'b0; tbl = 1'b0;
        case (mode_in)
            1:  begin e.ea = bx_in; c = 5; end
            2:  begin e.ea = si_in; c = 5; end
            3:  begin e.ea = di_in; c = 5; end
            4:  begin e.ea = bp_in; c = 5; bp_base = 1; end
            5:  begin e.ea = bx_in + d; c = 9; end
            6:  begin e.ea = bp_in + d; c = 9; bp_base = 1; end
            7:  begin e.ea = si_in + d; c = 9; end
            8:  begin e.ea = di_in + d; c = 9; end
            9:  begin e.ea = bx_in + si_in; c = 7; end
            10: begin e.ea = bx_in + di_in; c = 8; end
            11: begin e.ea = bp_in + si_in; c = 8; bp_base = 1; end
            12: begin e.ea = bp_in + di_in; c = 7; bp_base = 1; end
            13: begin e.ea = bx_in + si_in + d; c = 11; end
            14: begin e.ea = bx_in + di_in + d; c = 12; end
            15: begin e.ea = bp_in + si_in + d; c = 12; bp_base = 1; end
            16: begin e.ea = bp_in + di_in + d; c = 11; bp_base = 1; end
            17: begin e.ea = bx_in + {8'h00, al_in}; c = 11; tbl = 1; end
            default: begin e.ea = disp_in; c = 6; end
        endcase
        seg = bp_base ? seg_ss : seg_ds;
        ovr = 1'b1;
        if (!ovr_valid) ovr = 1'b0;
        else if (ovr_code == 8'h2E) seg = seg_cs;
        else if (ovr_code == 8'h3E) seg = seg_ds;
        else if (ovr_code == 8'h26) seg = seg_es;
        else if (ovr_code == 8'h36) seg = seg_ss;
        else ovr = 1'b0;
        if (ovr) c += 2;
        e.split = word_acc && e.ea[0] && !tbl;
        if (e.split) c += 4;
        e.cost = 5'(c);
        e.phys = {seg, 4'h0} + {4'h0, e.ea};
        e.tag = tag;
        return e;
    endfunction

    // Driver: present one request and push its expected result.
    task automatic send(input string tag, input logic [4:0] m, input logic [15:0] dsp,
                        input logic wide, input logic ov, input logic [7:0] oc,
                        input logic wa);
        @(negedge clk);
        mode_in = m; disp_in = dsp; disp_wide = wide;
        ovr_valid = ov; ovr_code = oc; word_acc = wa; req_valid = 1'b1;
        q.push_back(model(tag));
    endtask

    // Idle for a few cycles and confirm the outputs held (R9).
    task automatic idle(input int n);
        @(negedge clk);
        req_valid = 1'b0;
        for (int i = 0; i < n; i++) @(negedge clk);
        n_vec++;
        if (q.size() != 0 || ea_out !== last_exp.ea || phys_out !== last_exp.phys
            || cost_out !== last_exp.cost) begin
            n_bad++;
            $display("FAIL R9 hold: ea=%h phys=%h cost=%0d expected ea=%h phys=%h cost=%0d",
                     ea_out, phys_out, cost_out, last_exp.ea, last_exp.phys, last_exp.cost);
        end
    endtask

    // Monitor: compare each valid result against the queue head.
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            n_vec++;
            if (q.size() == 0) begin
                n_bad++;
                $display("FAIL R9 unexpected out_valid: ea=%h expected none", ea_out);
            end else begin
                exp_t e;
                e = q.pop_front();
                last_exp = e;
                if (ea_out !== e.ea || phys_out !== e.phys || cost_out !== e.cost
                    || split_out !== e.split) begin
                    n_bad++;
                    $display("FAIL %s: ea=%h phys=%h cost=%0d split=%b expected ea=%h phys=%h cost=%0d split=%b",
                             e.tag, ea_out, phys_out, cost_out, split_out,
                             e.ea, e.phys, e.cost, e.split);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #2_000_000;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        n_vec++;
        if (out_valid !== 1'b0 || ea_out !== 16'h0 || phys_out !== 20'h0 || cost_out !== 5'd0) begin
            n_bad++;
            $display("FAIL R9 reset: valid=%b ea=%h phys=%h cost=%0d expected all zero",
                     out_valid, ea_out, phys_out, cost_out);
        end
        rst_n = 1'b1;
        bx_in = 16'h0100; bp_in = 16'h0200; si_in = 16'h0011; di_in = 16'h0020; al_in = 8'h0F;

        send("R2 R5 direct",          5'd0,  16'h1234, 1'b0, 1'b0, 8'h00, 1'b0);
        send("R1 R2 R4 BX indirect",  5'd1,  16'h0000, 1'b0, 1'b0, 8'h00, 1'b0);
        send("R4 BP indirect SS",     5'd4,  16'h0000, 1'b0, 1'b0, 8'h00, 1'b0);
        send("R3 SI+d8 negative",     5'd7,  16'h00F0, 1'b0, 1'b0, 8'h00, 1'b0);
        send("R3 DI+d16",             5'd8,  16'h00F0, 1'b1, 1'b0, 8'h00, 1'b0);
        send("R3 BP+d8 positive",     5'd6,  16'hAB04, 1'b0, 1'b0, 8'h00, 1'b0);
        send("R5 BX+SI fast",         5'd9,  16'h0000, 1'b0, 1'b0, 8'h00, 1'b0);
        send("R5 BX+DI slow",         5'd10, 16'h0000, 1'b0, 1'b0, 8'h00, 1'b0);
        send("R4 R5 BP+SI slow",      5'd11, 16'h0000, 1'b0, 1'b0, 8'h00, 1'b0);
        send("R5 BP+DI+disp fast",    5'd16, 16'h0010, 1'b0, 1'b0, 8'h00, 1'b0);
        send("R5 BX+DI+disp slow",    5'd14, 16'h0300, 1'b1, 1'b0, 8'h00, 1'b0);
        send("R2 unused code",        5'd25, 16'h0444, 1'b0, 1'b0, 8'h00, 1'b0);
        idle(3);
        al_in = 8'hFF;
        send("R8 table lookup",       5'd17, 16'h0000, 1'b0, 1'b0, 8'h00, 1'b0);
        send("R8 table never split",  5'd17, 16'h0000, 1'b0, 1'b0, 8'h00, 1'b1);
        send("R6 override ES on BP",  5'd12, 16'h0000, 1'b0, 1'b1, 8'h26, 1'b0);
        send("R6 override CS",        5'd2,  16'h0000, 1'b0, 1'b1, 8'h2E, 1'b0);
        send("R6 unknown code",       5'd4,  16'h0000, 1'b0, 1'b1, 8'h3F, 1'b0);
        send("R6 code without valid", 5'd4,  16'h0000, 1'b0, 1'b0, 8'h26, 1'b0);
        si_in = 16'h0011;
        send("R6 R7 override+odd",    5'd11, 16'h0000, 1'b0, 1'b1, 8'h26, 1'b1);
        send("R7 odd word",           5'd2,  16'h0000, 1'b0, 1'b0, 8'h00, 1'b1);
        send("R7 even word",          5'd1,  16'h0000, 1'b0, 1'b0, 8'h00, 1'b1);
        idle(2);
        seg_ds = 16'hFFFF; bx_in = 16'hFFFF; si_in = 16'h0031;
        send("R1 R2 both wrap",       5'd13, 16'h0002, 1'b1, 1'b0, 8'h00, 1'b0);
        send("R6 override DS odd",    5'd1,  16'h0000, 1'b0, 1'b1, 8'h3E, 1'b1);
        send("R6 override SS",        5'd3,  16'h0000, 1'b0, 1'b1, 8'h36, 1'b0);
        idle(2);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule